// File: doc/BRIEF.md
# Synchronous serial slave receiver

This block receives characters from a serial link whose clock comes from an external master. It has no baud generator of its own. The serial clock and data inputs pass through a synchronizer into the system clock domain. A polarity control picks which transition of the serial clock samples a data bit. Bits arrive least significant first. A character is 8 bits long, or 9 bits when the wide-character select is set. When the last bit has been sampled, the character moves from the shift register into a two-entry receive buffer.

The buffer head is always visible at the read port. The low eight bits and the ninth bit come out on separate outputs, and a one-cycle read strobe pops the head. A ready flag stays high while the buffer holds anything, and an interrupt output mirrors it when the interrupt enable is set. A character that completes while the buffer is full is discarded and raises a sticky overrun flag, which stops all further reception. Software clears the overrun by dropping the receive enable or the port enable. Dropping the port enable also empties the buffer. A single-receive request input exists for compatibility with master-mode control words; in slave mode it has no effect.

Top module: `srx_slave_rx`

## Requirements
- R1: While rst_n is low at a rising clk edge, every output is 0 after that edge.
- R2: With clk_pol_i = 0 a bit is sampled on a falling transition of sck_i; with clk_pol_i = 1 it is sampled on a rising transition. Bits are taken least significant first.
- R3: With nine_bit_i = 0 a character is 8 sampled bits, presented on rd_data_o[7:0] with rd_bit8_o = 0.
- R4: With nine_bit_i = 1 a character is 9 sampled bits. The ninth (last) bit is presented on rd_bit8_o and the first eight on rd_data_o.
- R5: sck_i and sdat_i pass through a two-stage synchronizer. A completed character reaches the read port on the third rising clk edge after the edge that first registers the final sampling transition.
- R6: The buffer holds two characters in arrival order. rx_ready_o is 1 exactly while it is non-empty. rd_i pops the head when non-empty, and rd_data_o and rd_bit8_o are 0 when the buffer is empty.
- R7: irq_o is 1 exactly when rx_ready_o and irq_en_i are both 1.
- R8: A character completing while the buffer is full, with no pop in the same cycle, is discarded and sets overrun_o. The buffer contents are kept. While overrun_o is 1 no character is accepted.
- R9: rx_en_i = 0 clears overrun_o and abandons any partial character, while the buffer contents are kept.
- R10: port_en_i = 0 empties the buffer, clears overrun_o and abandons any partial character.
- R11: single_req_i has no effect. With rx_en_i = 0 no character is received whatever its value.
- R12: While port_en_i and rx_en_i stay 1, characters are accepted back to back with no idle gap required between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the external master |
| sdat_i | input | 1 | Serial data |
| port_en_i | input | 1 | Serial port enable; low resets the receiver |
| rx_en_i | input | 1 | Continuous receive enable |
| single_req_i | input | 1 | Single-receive request, ignored in slave mode |
| nine_bit_i | input | 1 | 1 selects 9-bit characters |
| clk_pol_i | input | 1 | 0: sample on falling sck_i, 1: on rising |
| irq_en_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Read strobe, pops the buffer head |
| rd_data_o | output | 8 | Low eight bits of the buffer head |
| rd_bit8_o | output | 1 | Ninth bit of the buffer head |
| rx_ready_o | output | 1 | Buffer non-empty |
| irq_o | output | 1 | Receive interrupt |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that rd_i is a single-cycle strobe issued by a reader who honours rx_ready_o. They also assume that the enables change only between clk edges. Beyond that, they rely only on the buffer and overrun rules, not on the serial waveform. The stimulus holds each level of sck_i for four system clocks, so the synchronizer never misses a transition. It changes clk_pol_i only while the synchronized clock is settled, so the change creates no spurious sample. The per-cycle model follows the same synchronizer timing, so any glitch the stimulus did cause would show up as a miscompare rather than be masked.

// File: rtl/srx_pkg.sv
// Package: shared types and widths for the synchronous slave receiver.
// Assumes a character is at most CHAR_W + 1 bits long.
package srx_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              bit8;
        logic [CHAR_W-1:0] data;
    } srx_char_t;
endpackage

// File: rtl/srx_sync_edge.sv
// Synchronizer and sampling-edge detector.
// Brings the external serial clock and data into the clk domain through
// STAGES flops each. Emits a one-cycle sample strobe on the transition
// chosen by pol_i. Assumes each sck_i level lasts longer than STAGES+1
// clk cycles.
module srx_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sdat_i,
    input  logic pol_i,
    output logic sample_o,
    output logic bit_o
);
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] dat_q;
    logic              sck_prev;
    logic              sck_cur;

    assign sck_cur = sck_q[STAGES-1];

    // Shift both inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= '0;
            dat_q    <= '0;
            sck_prev <= 1'b0;
        end else begin
            sck_q    <= {sck_q[STAGES-2:0], sck_i};
            dat_q    <= {dat_q[STAGES-2:0], sdat_i};
            sck_prev <= sck_cur;
        end
    end

    // Pick the sampling transition from the polarity control.
    always_comb begin
        if (pol_i) sample_o = sck_cur & ~sck_prev;
        else       sample_o = ~sck_cur & sck_prev;
        bit_o = dat_q[STAGES-1];
    end
endmodule

// File: rtl/srx_shifter.sv
// Receive shift register and bit counter.
// Places each sampled bit at its index (LSB first). On the last bit it
// registers the whole character and pulses done_o for one cycle.
// Assumes active_i low resets the frame position.
module srx_shifter
    import srx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active_i,
    input  logic      sample_i,
    input  logic      bit_i,
    input  logic      nine_i,
    output logic      done_o,
    output srx_char_t word_o
);
    localparam int SR_W  = CHAR_W + 1;
    localparam int CNT_W = $clog2(SR_W + 1);

    logic [SR_W-1:0]  sr_q;
    logic [SR_W-1:0]  sr_next;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;

    // Overlay the incoming bit at the current position.
    always_comb begin
        sr_next        = sr_q;
        sr_next[cnt_q] = bit_i;
        last_idx       = nine_i ? CNT_W'(CHAR_W) : CNT_W'(CHAR_W - 1);
    end

    // Advance the frame on each sample; hand over on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            done_o <= 1'b0;
            word_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (!active_i) begin
                cnt_q <= '0;
            end else if (sample_i) begin
                sr_q <= sr_next;
                if (cnt_q >= last_idx) begin
                    done_o      <= 1'b1;
                    word_o.data <= sr_next[CHAR_W-1:0];
                    word_o.bit8 <= nine_i & sr_next[CHAR_W];
                    cnt_q       <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/srx_rxbuf.sv
// Receive buffer: a DEPTH-entry FIFO with its head shown ahead.
// The caller pushes only when not full (or popping) and pops only when not
// empty. flush_i empties it and takes priority over push and pop.
module srx_rxbuf
    import srx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush_i,
    input  logic      push_i,
    input  srx_char_t push_data_i,
    input  logic      pop_i,
    output srx_char_t head_o,
    output logic      empty_o,
    output logic      full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    srx_char_t        mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] count_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store pushed characters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (push_i && !flush_i) begin
            mem_q[wr_ptr_q] <= push_data_i;
        end
    end

    // Maintain pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            if (push_i && !pop_i)      count_q <= count_q + 1'b1;
            else if (pop_i && !push_i) count_q <= count_q - 1'b1;
        end
    end

    // Present status and the head entry.
    always_comb begin
        empty_o = (count_q == '0);
        full_o  = (count_q == CNT_W'(DEPTH));
        head_o  = mem_q[rd_ptr_q];
    end
endmodule

// File: rtl/srx_slave_rx.sv
// Synchronous serial slave receiver, top level.
// Joins the synchronizer, the shift register and the receive buffer. Owns
// the overrun lockout and the read, ready and interrupt outputs. Assumes
// rd_i is a single-cycle strobe and that the controls are synchronous to clk.
module srx_slave_rx
    import srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BUF_DEPTH   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              sdat_i,
    input  logic              port_en_i,
    input  logic              rx_en_i,
    input  logic              single_req_i,
    input  logic              nine_bit_i,
    input  logic              clk_pol_i,
    input  logic              irq_en_i,
    input  logic              rd_i,
    output logic [CHAR_W-1:0] rd_data_o,
    output logic              rd_bit8_o,
    output logic              rx_ready_o,
    output logic              irq_o,
    output logic              overrun_o
);
    logic      sample;
    logic      bit_val;
    logic      active;
    logic      done;
    srx_char_t word;
    srx_char_t head;
    logic      buf_empty;
    logic      buf_full;
    logic      pop;
    logic      push;
    logic      ovr_set;
    logic      ovr_q;
    logic      unused_single_req;

    // The single-receive request has no role in slave mode.
    assign unused_single_req = single_req_i;

    srx_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .sdat_i   (sdat_i),
        .pol_i    (clk_pol_i),
        .sample_o (sample),
        .bit_o    (bit_val)
    );

    srx_shifter shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .sample_i (sample),
        .bit_i    (bit_val),
        .nine_i   (nine_bit_i),
        .done_o   (done),
        .word_o   (word)
    );

    srx_rxbuf #(.DEPTH(BUF_DEPTH)) buf_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (~port_en_i),
        .push_i      (push),
        .push_data_i (word),
        .pop_i       (pop),
        .head_o      (head),
        .empty_o     (buf_empty),
        .full_o      (buf_full)
    );

    // Decide reception, buffer traffic and overrun detection.
    always_comb begin
        active  = port_en_i & rx_en_i & ~ovr_q;
        pop     = rd_i & ~buf_empty;
        push    = done & port_en_i & rx_en_i & (~buf_full | pop);
        ovr_set = done & port_en_i & rx_en_i & buf_full & ~pop;
    end

    // Hold the overrun flag until an enable is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || !port_en_i || !rx_en_i) ovr_q <= 1'b0;
        else if (ovr_set)                     ovr_q <= 1'b1;
    end

    // Drive the read port and flags.
    always_comb begin
        rx_ready_o = ~buf_empty;
        rd_data_o  = buf_empty ? '0 : head.data;
        rd_bit8_o  = ~buf_empty & head.bit8;
        irq_o      = rx_ready_o & irq_en_i;
        overrun_o  = ovr_q;
    end
endmodule

// File: rtl/srx_slave_rx_chk.sv
// Checker for srx_slave_rx, attached with bind. Watches only ports.
module srx_slave_rx_chk
    import srx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              port_en_i,
    input logic              rx_en_i,
    input logic              rd_i,
    input logic [CHAR_W-1:0] rd_data_o,
    input logic              rd_bit8_o,
    input logic              rx_ready_o,
    input logic              overrun_o
);
    p_rxen_clears_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> !overrun_o);

    p_port_off_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en_i |=> (!rx_ready_o && !overrun_o));

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && port_en_i && rx_en_i) |=> overrun_o);

    p_ovr_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> rx_ready_o);

    p_head_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready_o && !rd_i && port_en_i) |=>
            (rx_ready_o && $stable(rd_data_o) && $stable(rd_bit8_o)));
endmodule

bind srx_slave_rx srx_slave_rx_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en_i  (port_en_i),
    .rx_en_i    (rx_en_i),
    .rd_i       (rd_i),
    .rd_data_o  (rd_data_o),
    .rd_bit8_o  (rd_bit8_o),
    .rx_ready_o (rx_ready_o),
    .overrun_o  (overrun_o)
);

// File: tb/srx_slave_rx_tb_top.sv
// Bench: behavioural per-cycle model compared every clock, plus read checks.
module srx_slave_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b1, sdat = 1'b0;
    logic       port_en = 1'b0, rx_en = 1'b0, single_req = 1'b0;
    logic       nine_bit = 1'b0, clk_pol = 1'b0, irq_en = 1'b0, rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit8, rx_ready, irq, overrun;

    int    vectors = 0;
    int    fails = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    srx_slave_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdat_i(sdat),
        .port_en_i(port_en), .rx_en_i(rx_en), .single_req_i(single_req),
        .nine_bit_i(nine_bit), .clk_pol_i(clk_pol), .irq_en_i(irq_en),
        .rd_i(rd), .rd_data_o(rd_data), .rd_bit8_o(rd_bit8),
        .rx_ready_o(rx_ready), .irq_o(irq), .overrun_o(overrun)
    );

    // Reference model state
    bit       m_f1, m_f2, m_pv, m_d1, m_d2;
    int       m_cnt;
    bit [8:0] m_sr, m_word;
    bit       m_done, m_ovr;
    bit [8:0] q[$];

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model update on each edge, comparison just after it.
    always @(posedge clk) begin : model
        bit act, edg, nd, popm, fullo;
        bit [8:0] nw;
        int lst;
        if (!rst_n) begin
            m_f1 = 0; m_f2 = 0; m_pv = 0; m_d1 = 0; m_d2 = 0;
            m_cnt = 0; m_sr = 0; m_word = 0; m_done = 0; m_ovr = 0;
            q.delete();
        end else begin
            act = port_en && rx_en && !m_ovr;
            edg = clk_pol ? (m_f2 && !m_pv) : (!m_f2 && m_pv);
            lst = nine_bit ? 8 : 7;
            nd = 0; nw = m_word;
            if (!act) m_cnt = 0;
            else if (edg) begin
                m_sr[m_cnt] = m_d2;
                if (m_cnt >= lst) begin
                    nd = 1; nw = {nine_bit & m_sr[8], m_sr[7:0]}; m_cnt = 0;
                end else m_cnt++;
            end
            popm  = rd && q.size() > 0;
            fullo = q.size() == 2;
            if (!port_en) begin
                q.delete(); m_ovr = 0;
            end else begin
                if (popm) void'(q.pop_front());
                if (!rx_en) m_ovr = 0;
                else if (m_done) begin
                    if (fullo && !popm) m_ovr = 1;
                    else q.push_back(m_word);
                end
            end
            m_done = nd; m_word = nw;
            m_pv = m_f2; m_f2 = m_f1; m_f1 = sck;
            m_d2 = m_d1; m_d1 = sdat;
        end
        #1;
        check(tag, "rx_ready", rx_ready, q.size() > 0);
        check(tag, "rd_data", rd_data, q.size() > 0 ? q[0][7:0] : 0);
        check(tag, "rd_bit8", rd_bit8, q.size() > 0 ? q[0][8] : 0);
        check(tag, "overrun", overrun, m_ovr);
        check("R7", "irq", irq, (q.size() > 0) && irq_en);
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame, LSB first, sampled on the edge chosen by clk_pol.
    task automatic send_frame(input bit [8:0] v, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sdat = v[i];
            sck  = clk_pol ? 1'b0 : 1'b1;
            wait_clk(HALF_BIT);
            sck  = ~sck;
            wait_clk(HALF_BIT);
        end
        sck = clk_pol ? 1'b0 : 1'b1;
        wait_clk(6);
    endtask

    task automatic read_expect(input string req, input bit [7:0] d, input bit b8);
        @(negedge clk);
        check(req, "ready before read", rx_ready, 1);
        check(req, "read data", rd_data, d);
        check(req, "read bit8", rd_bit8, b8);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin : stim
        wait_clk(4);
        tag = "R1";
        check("R1", "reset ready", rx_ready, 0);
        check("R1", "reset overrun", overrun, 0);
        check("R1", "reset data", rd_data, 0);
        rst_n = 1'b1; port_en = 1'b1; rx_en = 1'b1; irq_en = 1'b1;
        wait_clk(6);

        tag = "R3";
        send_frame(9'h0A5, 8);
        check("R5", "ready after frame", rx_ready, 1);
        check("R7", "irq with enable", irq, 1);
        irq_en = 1'b0;
        @(negedge clk);
        check("R7", "irq masked", irq, 0);
        read_expect("R3", 8'hA5, 0);

        tag = "R4";
        nine_bit = 1'b1;
        send_frame(9'h13C, 9);
        read_expect("R4", 8'h3C, 1);

        tag = "R2";
        clk_pol = 1'b1;
        wait_clk(5);
        sck = 1'b0;
        wait_clk(5);
        send_frame(9'h0C3, 9);
        read_expect("R2", 8'hC3, 0);
        nine_bit = 1'b0;
        send_frame(9'h05A, 8);
        read_expect("R2", 8'h5A, 0);
        clk_pol = 1'b0;
        wait_clk(5);
        sck = 1'b1;
        wait_clk(5);

        tag = "R12";
        irq_en = 1'b1;
        send_frame(9'h011, 8);
        send_frame(9'h022, 8);
        read_expect("R6", 8'h11, 0);
        read_expect("R6", 8'h22, 0);
        @(negedge clk);
        check("R6", "empty after reads", rx_ready, 0);
        check("R6", "empty data zero", rd_data, 0);

        tag = "R8";
        send_frame(9'h031, 8);
        send_frame(9'h032, 8);
        send_frame(9'h033, 8);
        check("R8", "overrun set", overrun, 1);
        send_frame(9'h034, 8);
        read_expect("R8", 8'h31, 0);
        read_expect("R8", 8'h32, 0);
        @(negedge clk);
        check("R8", "nothing after overrun", rx_ready, 0);
        check("R8", "overrun held", overrun, 1);

        tag = "R9";
        rx_en = 1'b0;
        wait_clk(2);
        check("R9", "overrun cleared", overrun, 0);
        rx_en = 1'b1;
        send_frame(9'h0FF, 3);
        rx_en = 1'b0;
        wait_clk(2);
        rx_en = 1'b1;
        wait_clk(2);
        send_frame(9'h096, 8);
        read_expect("R9", 8'h96, 0);

        tag = "R10";
        send_frame(9'h041, 8);
        send_frame(9'h042, 8);
        send_frame(9'h043, 8);
        check("R10", "overrun before disable", overrun, 1);
        port_en = 1'b0;
        wait_clk(2);
        check("R10", "buffer flushed", rx_ready, 0);
        check("R10", "overrun cleared", overrun, 0);
        port_en = 1'b1;
        send_frame(9'h0FF, 5);
        port_en = 1'b0;
        wait_clk(2);
        port_en = 1'b1;
        wait_clk(2);
        send_frame(9'h069, 8);
        read_expect("R10", 8'h69, 0);

        tag = "R11";
        rx_en = 1'b0;
        single_req = 1'b1;
        send_frame(9'h077, 8);
        check("R11", "no receive with request", rx_ready, 0);
        single_req = 1'b0;
        rx_en = 1'b1;
        single_req = 1'b1;
        send_frame(9'h078, 8);
        single_req = 1'b0;
        read_expect("R11", 8'h78, 0);

        wait_clk(4);
        summary();
    end
endmodule